// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides whether one memory access may use a translated page. It receives the leaf page table entry found by the walker, the kind of access (load, store or instruction fetch), whether the processor is in user state, and a three-bit authority mask that the supervisor applies on top of the entry's own rights. It returns the set of rights actually granted (read, write, execute), a fault flag and a bit vector of fault causes that the fault-delivery logic can report.

Three rules apply, in a fixed order. First, an instruction fetch from a page whose attribute field marks non-idempotent I/O space is refused at once as guarded storage; no rights are evaluated. Otherwise the granted rights come from the entry's access-authority bits. A user access to a privileged entry gets no rights. A supervisor access to a non-privileged entry also has its rights narrowed by the authority mask. Finally, the right needed by the access type is looked up in the granted set, and if it is missing a protection fault is raised. A store that faults also carries a store indicator.

By default the result is registered and appears one clock after the request. A parameter selects a purely combinational variant with the same ports.

Top module: `pp_perm_check`

## Requirements
- R1: A fetch (access code 2) from an entry whose attribute field, entry bits [5:4] (big-endian bits 58:59), equals 2'b10 faults with cause exactly 3'b001 (guard bit, cause bit 0), granted rights 3'b000, and no protection bit, whatever the authority bits are.
- R2: The attribute value 2'b10 has no effect on loads (code 0), stores (code 1) or code 3; those are judged only by the rights rules.
- R3: In user state (user=1), an entry with the privileged bit (entry bit 3) set grants no rights (3'b000).
- R4: In user state, a non-privileged entry grants exactly its authority bits, entry bits [2:0] (bit 2 read, bit 1 write, bit 0 execute); the authority mask is ignored.
- R5: In supervisor state (user=0), a privileged entry grants exactly its authority bits; the authority mask is ignored.
- R6: In supervisor state, a non-privileged entry grants its authority bits ANDed with the authority mask (mask bit 2 read, bit 1 write, bit 0 execute).
- R7: Access code 0 needs read, code 1 needs write, code 2 needs execute, and the reserved code 3 needs read; when the needed right is absent from the granted set the result faults with the protection bit (cause bit 1) set.
- R8: A protection fault on a store (code 1) also sets the store indicator (cause bit 2), giving cause 3'b110; no other access ever sets it.
- R9: When no fault occurs, the fault flag is 0 and the cause vector is 3'b000; the fault flag always equals the OR of the cause bits.
- R10: With the default registered variant, a request accepted with in_valid=1 at a rising edge produces out_valid=1 and its result after that same edge, out_valid is 0 after any edge without a request, and out_valid is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| pte | input | PTE_W (64) | Leaf page table entry |
| acc | input | 2 | Access code: 0 load, 1 store, 2 fetch, 3 reserved (judged as load) |
| user | input | 1 | 1 = user state, 0 = supervisor state |
| amask | input | 3 | Supervisor authority mask: bit 2 read, bit 1 write, bit 0 execute |
| out_valid | output | 1 | Result present |
| out_perm | output | 3 | Granted rights: bit 2 read, bit 1 write, bit 0 execute |
| out_fault | output | 1 | Access refused |
| out_cause | output | 3 | Cause bits: 0 guarded fetch, 1 protection, 2 store |

## Verification
The bench sweeps every combination of the low six entry bits, every access code and both privilege states against several masks, so a design that applied the guard rule to loads or stores would fault on I/O pages that should be readable, and one that checked the guard after the rights would add a protection bit to a guarded-fetch cause. A design that applied the mask to user accesses or to privileged entries would strip rights that should be granted, and one that skipped it for supervisor accesses to ordinary pages would grant writes the mask forbids. The reserved access code is checked to need read, catching a decoder that falls through to execute or to nothing, and a store indicator set on non-store faults or omitted on store faults shows up in the cause comparison. Idle cycles between requests catch an output-valid that is held or delayed.

// File: rtl/pp_perm_pkg.sv
package pp_perm_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   localparam int RIGHTS_W = 3;
   localparam int RT_READ  = 2;
   localparam int RT_WRITE = 1;
   localparam int RT_EXEC  = 0;

   localparam int CAUSE_W     = 3;
   localparam int CB_GUARD    = 0;
   localparam int CB_PROT     = 1;
   localparam int CB_STORE    = 2;

   localparam logic [1:0] ATT_NONIDEM_IO = 2'b10;

   typedef struct packed {
      logic [RIGHTS_W-1:0] perm;
      logic                fault;
      logic [CAUSE_W-1:0]  cause;
   } verdict_t;

endpackage

// File: rtl/pp_attr_guard.sv
module pp_attr_guard
   import pp_perm_pkg::*;
(
   input  logic [1:0] att,
   input  acc_e       acc,
   output logic       guard_hit
);

   always_comb begin
      guard_hit = (acc == ACC_FETCH) && (att == ATT_NONIDEM_IO);
   end

endmodule

// File: rtl/pp_auth_resolve.sv
module pp_auth_resolve
   import pp_perm_pkg::*;
#(
   parameter bit MASK_EN = 1'b1
) (
   input  logic [RIGHTS_W-1:0] eaa,
   input  logic                priv,
   input  logic                user,
   input  logic [RIGHTS_W-1:0] amask,
   output logic [RIGHTS_W-1:0] granted
);

   logic [RIGHTS_W-1:0] narrowed;

   generate
      if (MASK_EN) begin : g_mask
         assign narrowed = eaa & amask;
      end else begin : g_nomask
         logic unused_mask;
         assign unused_mask = ^amask;
         assign narrowed    = eaa;
      end
   endgenerate

   always_comb begin
      unique casez ({user, priv})
         2'b11:   granted = '0;
         2'b10:   granted = eaa;
         2'b01:   granted = eaa;
         default: granted = narrowed;
      endcase
   end

endmodule

// File: rtl/pp_need_check.sv
module pp_need_check
   import pp_perm_pkg::*;
(
   input  acc_e                acc,
   input  logic [RIGHTS_W-1:0] granted,
   output logic                missing,
   output logic                is_store
);

   logic [RIGHTS_W-1:0] need;

   always_comb begin
      need = '0;
      unique case (acc)
         ACC_STORE: need[RT_WRITE] = 1'b1;
         ACC_FETCH: need[RT_EXEC]  = 1'b1;
         default:   need[RT_READ]  = 1'b1;
      endcase
      missing  = |(need & ~granted);
      is_store = (acc == ACC_STORE);
   end

endmodule

// File: rtl/pp_perm_check.sv
module pp_perm_check
   import pp_perm_pkg::*;
#(
   parameter int PTE_W    = 64,
   parameter int ATT_LO   = 4,
   parameter int PRIV_BIT = 3,
   parameter bit MASK_EN  = 1'b1,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [PTE_W-1:0]    pte,
   input  logic [1:0]          acc,
   input  logic                user,
   input  logic [2:0]          amask,
   output logic                out_valid,
   output logic [2:0]          out_perm,
   output logic                out_fault,
   output logic [2:0]          out_cause
);

   localparam int ATT_HI = ATT_LO + 1;

   generate
      if (PTE_W < 8) begin : g_chk_width
         $error("pp_perm_check: PTE_W too small");
      end
      if (ATT_HI >= PTE_W) begin : g_chk_att
         $error("pp_perm_check: attribute field outside entry");
      end
      if (PRIV_BIT < RIGHTS_W || PRIV_BIT >= PTE_W ||
          (PRIV_BIT >= ATT_LO && PRIV_BIT <= ATT_HI)) begin : g_chk_priv
         $error("pp_perm_check: privilege bit overlaps another field");
      end
   endgenerate

   acc_e                acc_t;
   logic                guard_hit;
   logic [RIGHTS_W-1:0] granted;
   logic                missing;
   logic                is_store;
   verdict_t            vd;
   logic                unused_pte;

   assign acc_t      = acc_e'(acc);
   assign unused_pte = ^pte;

   pp_attr_guard u_guard (
      .att       (pte[ATT_HI:ATT_LO]),
      .acc       (acc_t),
      .guard_hit (guard_hit)
   );

   pp_auth_resolve #(.MASK_EN(MASK_EN)) u_auth (
      .eaa     (pte[RIGHTS_W-1:0]),
      .priv    (pte[PRIV_BIT]),
      .user    (user),
      .amask   (amask),
      .granted (granted)
   );

   pp_need_check u_need (
      .acc      (acc_t),
      .granted  (granted),
      .missing  (missing),
      .is_store (is_store)
   );

   always_comb begin
      vd.cause = '0;
      vd.perm  = granted;
      if (guard_hit) begin
         vd.perm            = '0;
         vd.cause[CB_GUARD] = 1'b1;
      end else if (missing) begin
         vd.cause[CB_PROT]  = 1'b1;
         vd.cause[CB_STORE] = is_store;
      end
      vd.fault = |vd.cause;
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               out_perm  <= '0;
               out_fault <= 1'b0;
               out_cause <= '0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  out_perm  <= vd.perm;
                  out_fault <= vd.fault;
                  out_cause <= vd.cause;
               end
            end
         end

         // R10: one request in, one result out on the next edge
         p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
         p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
         // R3: user access to privileged entry gets nothing
         p_user_priv_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && user && pte[PRIV_BIT]) |=> (out_perm == '0));
         // R8: store indicator only on store accesses
         p_store_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_cause[CB_STORE]) |-> ($past(acc) == ACC_STORE));
      end else begin : g_comb
         assign out_valid = in_valid;
         assign out_perm  = vd.perm;
         assign out_fault = vd.fault;
         assign out_cause = vd.cause;
      end
   endgenerate

   // R9: fault flag agrees with the cause vector
   p_clean_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_fault == (|out_cause)));
   // R1: guarded fetch carries no protection or store cause
   p_guard_alone_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_cause[CB_GUARD]) |-> (out_cause[CB_PROT] == 1'b0 &&
                                             out_cause[CB_STORE] == 1'b0 &&
                                             out_perm == '0));
   // R8: store indicator implies a protection fault
   p_store_needs_prot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_cause[CB_STORE]) |-> out_cause[CB_PROT]);

endmodule

// File: tb/tb_pp_perm_check.sv
`timescale 1ns/1ps
module tb_pp_perm_check;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] pte = '0;
   logic [1:0]  acc = '0;
   logic        user = 1'b0;
   logic [2:0]  amask = '0;
   logic        out_valid;
   logic [2:0]  out_perm;
   logic        out_fault;
   logic [2:0]  out_cause;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      logic       v;
      logic [2:0] p;
      logic       f;
      logic [2:0] c;
      string      tag;
   } exp_t;

   exp_t sb[$];

   always #2.5 clk = ~clk;

   pp_perm_check dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pte(pte), .acc(acc),
      .user(user), .amask(amask), .out_valid(out_valid), .out_perm(out_perm),
      .out_fault(out_fault), .out_cause(out_cause)
   );

   function automatic exp_t model(input logic [63:0] e, input logic [1:0] a,
                                  input logic u, input logic [2:0] m);
      exp_t r;
      logic [2:0] need;
      r.v = 1'b1;
      r.c = 3'b000;
      if (a == 2'd2 && e[5:4] == 2'b10) begin
         r.p = 3'b000; r.c = 3'b001; r.tag = "R1";
      end else begin
         if (u && e[3])      begin r.p = 3'b000;        r.tag = "R3"; end
         else if (u)         begin r.p = e[2:0];        r.tag = "R4"; end
         else if (e[3])      begin r.p = e[2:0];        r.tag = "R5"; end
         else                begin r.p = e[2:0] & m;    r.tag = "R6"; end
         need = (a == 2'd1) ? 3'b010 : (a == 2'd2) ? 3'b001 : 3'b100;
         if ((need & ~r.p) != 3'b000) begin
            if (a == 2'd1) begin r.c = 3'b110; r.tag = {r.tag, "/R7/R8"}; end
            else           begin r.c = 3'b010; r.tag = {r.tag, "/R7"};    end
         end else begin
            r.tag = {r.tag, "/R9"};
         end
         if (e[5:4] == 2'b10) r.tag = {r.tag, "/R2"};
      end
      r.f = (r.c != 3'b000);
      return r;
   endfunction

   task automatic drive(input logic [63:0] e, input logic [1:0] a,
                        input logic u, input logic [2:0] m);
      @(negedge clk);
      in_valid = 1'b1; pte = e; acc = a; user = u; amask = m;
      sb.push_back(model(e, a, u, m));
   endtask

   task automatic idle();
      exp_t r;
      @(negedge clk);
      in_valid = 1'b0; pte = 64'hDEAD_BEEF_0000_003F; acc = 2'd1;
      r.v = 1'b0; r.p = '0; r.f = 1'b0; r.c = '0; r.tag = "R10";
      sb.push_back(r);
   endtask

   // monitor: compare each output cycle with the head of the scoreboard
   initial begin
      exp_t x;
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && sb.size() > 0) begin
            x = sb.pop_front();
            checks++;
            if (out_valid !== x.v) begin
               failures++;
               $display("FAIL R10 out_valid actual=%0b expected=%0b", out_valid, x.v);
            end else if (x.v && (out_perm !== x.p || out_fault !== x.f || out_cause !== x.c)) begin
               failures++;
               $display("FAIL %s perm/fault/cause actual=%b/%b/%b expected=%b/%b/%b",
                        x.tag, out_perm, out_fault, out_cause, x.p, x.f, x.c);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_fault !== 1'b0 || out_cause !== 3'b000) begin
         failures++;
         $display("FAIL R10 reset state actual=%b/%b/%b expected=0/0/000",
                  out_valid, out_fault, out_cause);
      end
      rst_n = 1'b1;

      // directed corner cases
      drive(64'h0000_0000_0000_0027, 2'd2, 1'b0, 3'b111); // R1 guard with full rights
      drive(64'h0000_0000_0000_0024, 2'd0, 1'b0, 3'b111); // R2 load from I/O page
      drive(64'h0000_0000_0000_0022, 2'd1, 1'b1, 3'b000); // R2 store from I/O page
      idle();
      drive(64'h0000_0000_0000_000F, 2'd0, 1'b1, 3'b111); // R3
      drive(64'h0000_0000_0000_0006, 2'd1, 1'b1, 3'b000); // R4 mask ignored
      drive(64'h0000_0000_0000_000F, 2'd1, 1'b0, 3'b000); // R5 mask ignored
      drive(64'h0000_0000_0000_0007, 2'd1, 1'b0, 3'b101); // R6/R8 mask strips write
      drive(64'h0000_0000_0000_0004, 2'd3, 1'b0, 3'b111); // R7 reserved needs read
      drive(64'h0000_0000_0000_0003, 2'd3, 1'b1, 3'b111); // R7 reserved, no read
      idle();
      idle();

      // sweep
      for (int lo = 0; lo < 64; lo++) begin
         for (int a = 0; a < 4; a++) begin
            for (int u = 0; u < 2; u++) begin
               for (int mi = 0; mi < 3; mi++) begin
                  logic [2:0]  m;
                  logic [63:0] e;
                  m = (mi == 0) ? 3'b111 : (mi == 1) ? 3'b000 : 3'(lo + a + 1);
                  e = (64'hA5C3_96E1_0F00_0000 ^ (64'(lo * 4 + a) << 24)) | 64'(lo);
                  drive(e, 2'(a), u[0], m);
               end
            end
            if ((lo % 5) == 0) idle();
         end
      end
      idle();
      idle();
      repeat (3) @(negedge clk);
      checks++;
      if (sb.size() != 0) begin
         failures++;
         $display("FAIL R10 pending results actual=%0d expected=0", sb.size());
      end
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule